// File: doc/BRIEF.md
# Dual-Direction Latched/Registered Bus Transceiver

This block passes data between two buses, A and B, one lane per direction. Each lane has its own controls: a hold-gate input, a transfer clock pin, an active-low clock gate and an active-low drive enable. With the hold gate high, the lane is transparent and forwards its input straight through. With the gate low, the lane presents a stored word. That word changes only when a rising transition on the lane's transfer clock pin is seen while the clock gate is low. Both lanes run on one system clock. The transfer clock pin is sampled on that clock, and a rising transition means it was low at one system edge and high at the next.

Each bus is split into three signals: an input word, a "driven" flag from whatever is driving the bus, and the lane's output word with its drive enable. Each input has a keeper. When the driven flag drops, the lane sees the last word that was actively driven, not a floating value.

The buses are level signals, so no valid/ready handshake applies and there is no back-pressure. An output word is meaningful only while its enable is high. Driving both buses at once is the integrator's error: the block does not arbitrate it.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While a lane's hold gate is high, its output equals its effective input in the same cycle. The effective input is the input word when the driven flag is high, and otherwise the keeper value.
- R2: While the hold gate is high, the stored word takes the effective input at every system clock edge. After the gate goes low, the output shows the effective input from the last edge at which the gate was high.
- R3: With the hold gate low and the clock gate low, a transfer clock pin that reads 0 at one system edge and 1 at the next loads the effective input at that second edge.
- R4: With the clock gate high, transfer clock transitions leave the stored word unchanged.
- R5: With the hold gate low and no rising transfer clock transition, the stored word is held. This includes a transfer clock pin held at a constant high level.
- R6: A lane's output enable is high exactly when its active-low drive enable is low and reset is not asserted.
- R7: When a bus's driven flag is low, the keeper holds the last word seen with the flag high, and the lane uses that word as its input.
- R8: The B-to-A lane behaves like the A-to-B lane under its own controls. Activity on one lane does not affect the other lane.
- R9: Reset clears both stored words and both keepers to 0 and holds both output enables low. A transfer clock pin that is already high when reset ends is not treated as a rising transition.
- R10: Each output enable depends only on its own lane. If both drive enables are low together, both outputs are driven with no arbitration. This state is illegal use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 18 | Word present on bus A |
| a_drv | input | 1 | Bus A is actively driven by another agent |
| b_in | input | 18 | Word present on bus B |
| b_drv | input | 1 | Bus B is actively driven by another agent |
| ab_le | input | 1 | A-to-B hold gate (high = transparent) |
| ab_ck | input | 1 | A-to-B transfer clock pin |
| ab_cen_n | input | 1 | A-to-B clock gate, active low |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ba_le | input | 1 | B-to-A hold gate |
| ba_ck | input | 1 | B-to-A transfer clock pin |
| ba_cen_n | input | 1 | B-to-A clock gate, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| b_out | output | 18 | Word driven onto bus B |
| b_en | output | 1 | B is driven by this block |
| a_out | output | 18 | Word driven onto bus A |
| a_en | output | 1 | A is driven by this block |

## Verification
Transparent runs with a changing input word show whether the output follows combinationally or lags by one register. Hold-gate falls followed by input changes show which cycle's value is kept. Transfer clock toggles are tried with the clock gate low and high, and with the pin held high. These separate true edge loading from level loading and from gated edges. The driven flag is dropped during transparent flow to expose the keeper. A long mixed run drives both lanes together to show that neither lane disturbs the other.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DATA_W = 18;

  typedef struct packed {
    logic le;
    logic ck;
    logic cen_n;
    logic oe_n;
  } lane_ctl_t;
endpackage

// File: rtl/bus_keeper.sv
module bus_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         drv,
  output logic [W-1:0] dout
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= '0;
    else if (drv) held <= din;
  end

  assign dout = drv ? din : held;

  // R7
  keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv |=> $stable(held));
  // R7
  keep_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv |=> held == $past(din));
endmodule

// File: rtl/lane_store.sv
module lane_store #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         le,
  input  logic         ck,
  input  logic         cen_n,
  output logic [W-1:0] q_reg
);
  logic ck_q;
  logic rise;
  logic load;

  assign rise = ck & ~ck_q;
  assign load = le | (rise & ~cen_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q  <= 1'b1;
      q_reg <= '0;
    end else begin
      ck_q <= ck;
      if (load) q_reg <= d;
    end
  end

  // R2
  track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> q_reg == $past(d));
  // R3
  edge_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && ck && !ck_q && !cen_n) |=> q_reg == $past(d));
  // R4
  cen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && cen_n) |=> $stable(q_reg));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && (ck == ck_q)) |=> $stable(q_reg));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         drv,
  input  lane_ctl_t    ctl,
  output logic [W-1:0] q_out,
  output logic         q_en
);
  logic [W-1:0] eff;
  logic [W-1:0] stored;

  bus_keeper #(.W(W)) u_keep (
    .clk(clk), .rst_n(rst_n), .din(din), .drv(drv), .dout(eff)
  );

  lane_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .d(eff),
    .le(ctl.le), .ck(ctl.ck), .cen_n(ctl.cen_n), .q_reg(stored)
  );

  assign q_out = ctl.le ? eff : stored;
  assign q_en  = rst_n & ~ctl.oe_n;

  // R1
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.le && drv) |-> q_out == din);
  // R6
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.oe_n |-> !q_en);
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_drv,
  input  logic [W-1:0] b_in,
  input  logic         b_drv,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ab_cen_n,
  input  logic         ab_oe_n,
  input  logic         ba_le,
  input  logic         ba_ck,
  input  logic         ba_cen_n,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_en,
  output logic [W-1:0] a_out,
  output logic         a_en
);
  localparam int LANES = 2;

  logic [W-1:0] l_din  [LANES];
  logic         l_drv  [LANES];
  lane_ctl_t    l_ctl  [LANES];
  logic [W-1:0] l_q    [LANES];
  logic         l_en   [LANES];

  assign l_din[0] = a_in;
  assign l_drv[0] = a_drv;
  assign l_ctl[0] = '{le: ab_le, ck: ab_ck, cen_n: ab_cen_n, oe_n: ab_oe_n};
  assign l_din[1] = b_in;
  assign l_drv[1] = b_drv;
  assign l_ctl[1] = '{le: ba_le, ck: ba_ck, cen_n: ba_cen_n, oe_n: ba_oe_n};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n), .din(l_din[g]), .drv(l_drv[g]),
      .ctl(l_ctl[g]), .q_out(l_q[g]), .q_en(l_en[g])
    );
  end

  assign b_out = l_q[0];
  assign b_en  = l_en[0];
  assign a_out = l_q[1];
  assign a_en  = l_en[1];

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!a_en && !b_en));
endmodule

// File: tb/dual_bus_xcvr_test.sv
`timescale 1ns/1ps
module dual_bus_xcvr_test;
  localparam int W = 18;

  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic [W-1:0] din [2];
  logic drv [2], le [2], ck [2], cen [2], oe [2];
  logic [W-1:0] b_out, a_out;
  logic b_en, a_en;

  dual_bus_xcvr uut (
    .clk(clk), .rst_n(rst_n),
    .a_in(din[0]), .a_drv(drv[0]), .b_in(din[1]), .b_drv(drv[1]),
    .ab_le(le[0]), .ab_ck(ck[0]), .ab_cen_n(cen[0]), .ab_oe_n(oe[0]),
    .ba_le(le[1]), .ba_ck(ck[1]), .ba_cen_n(cen[1]), .ba_oe_n(oe[1]),
    .b_out(b_out), .b_en(b_en), .a_out(a_out), .a_en(a_en)
  );

  // behavioural reference state
  logic [W-1:0] mk [2];
  logic [W-1:0] ms [2];
  logic mp [2];
  int total = 0, bad = 0, contention = 0;
  string phase = "R9";

  function automatic logic [W-1:0] m_eff(int i);
    return drv[i] ? din[i] : mk[i];
  endfunction

  task automatic cmp(string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("b_out", b_out, le[0] ? m_eff(0) : ms[0]);
    cmp("b_en", W'(b_en), W'(rst_n && !oe[0]));
    cmp("a_out", a_out, le[1] ? m_eff(1) : ms[1]);
    cmp("a_en", W'(a_en), W'(rst_n && !oe[1]));
  endtask

  task automatic update();
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        mk[i] = '0; ms[i] = '0; mp[i] = 1'b1;
      end else begin
        logic [W-1:0] e;
        e = m_eff(i);
        if (le[i]) ms[i] = e;
        else if (ck[i] && !mp[i] && !cen[i]) ms[i] = e;
        mp[i] = ck[i];
        if (drv[i]) mk[i] = din[i];
      end
    end
  endtask

  task automatic step();
    #1 check_all();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  always @(negedge clk)
    if (a_en && b_en) contention++;

  task automatic lane_seq(int i);
    le[i] = 1; oe[i] = 0; cen[i] = 0; ck[i] = 0; drv[i] = 1;
    phase = "R1";
    din[i] = 18'h00001; step();
    din[i] = 18'h3FFFF; step();
    din[i] = 18'h15A5A; step();
    phase = "R2";
    din[i] = 18'h2AAAA; step();
    le[i] = 0;
    din[i] = 18'h00F0F; step();
    din[i] = 18'h11111; step();
    phase = "R3";
    din[i] = 18'h12345; ck[i] = 1; step();
    din[i] = 18'h22222; step();
    ck[i] = 0; step();
    ck[i] = 1; din[i] = 18'h33333; step();
    phase = "R4";
    cen[i] = 1; ck[i] = 0; din[i] = 18'h0ABCD; step();
    ck[i] = 1; step();
    ck[i] = 0; step();
    ck[i] = 1; step();
    phase = "R5";
    cen[i] = 0; din[i] = 18'h1BEEF; step();
    din[i] = 18'h00077; step();
    phase = "R7";
    le[i] = 1; din[i] = 18'h2C0DE; step();
    drv[i] = 0; din[i] = 18'h3DEAD; step();
    din[i] = 18'h0F00D; step();
    le[i] = 0; ck[i] = 0; step();
    ck[i] = 1; step();
    drv[i] = 1; step();
    phase = "R6";
    oe[i] = 1; step();
    oe[i] = 0; step();
    oe[i] = 1; step();
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      din[i] = '0; drv[i] = 1; le[i] = 0; ck[i] = 0; cen[i] = 1; oe[i] = 1;
      mk[i] = '0; ms[i] = '0; mp[i] = 1'b1;
    end
    @(negedge clk);
    phase = "R9";
    ck[0] = 1; cen[0] = 0; oe[0] = 0; din[0] = 18'h3C3C3;
    step(); step(); step();
    rst_n = 1; step(); step();
    oe[0] = 1; ck[0] = 0;
    lane_seq(0);
    // B-to-A lane while A-to-B keeps clocking
    le[0] = 0; cen[0] = 0;
    fork
      lane_seq(1);
      begin
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          ck[0] = ~ck[0]; din[0] = W'($urandom);
        end
      end
    join
    phase = "R10";
    oe[0] = 0; oe[1] = 0; step(); step();
    oe[0] = 1; oe[1] = 1; step();
    total++;
    if (contention == 0) begin
      bad++;
      $display("FAIL R10 contention: actual=%0d expected>0", contention);
    end else $display("note: R10 contention flagged in %0d cycles", contention);
    phase = "R8";
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 2; i++) begin
        din[i] = W'($urandom);
        drv[i] = ($urandom % 4) != 0;
        le[i] = ($urandom % 3) == 0;
        ck[i] = $urandom;
        cen[i] = ($urandom % 3) == 0;
      end
      oe[0] = $urandom;
      oe[1] = oe[0] ? 1'($urandom) : 1'b1;
      step();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule